// File: doc/BRIEF.md
# Two-Stream Banked Refill Buffer

This block sits between a host that pushes data in fixed-size blocks and a consumer that pulls bytes one at a time. It keeps two separate streams. The control stream has two banks of 128 bytes. The sample stream has four 64-byte banks. In two-channel mode each sample channel owns two of those banks. In single-channel mode they are joined into two 128-byte banks that serve channel 0 alone. Each stream, or each channel, cycles through its banks in a fixed ping-pong order. The host fills one bank while the consumer drains the other.

When a stream has an empty bank waiting to be filled, its bit in a three-bit request-type output is set and the active-low interrupt line goes low. The host reads the request-type bits to learn which stream needs data, then writes one bank-sized block into it. A read from a bank that is not completely written returns zero and raises an underrun flag. Such a read does not move any pointer.

Top module: `stream_bank_buffer`

## Requirements
- R1: During and after reset all banks are empty. `req_type` is 3'b111 when `cfg_one_chan`=0 and 3'b101 when it is 1. `irq_n` is 0 and `rd_valid` is 0.
- R2: `req_type` bit 2 belongs to the control stream, bit 1 to sample channel 1 and bit 0 to sample channel 0. A bit is 1 while the next bank that stream will fill is empty. It clears once every bank of that stream holds a complete block. It sets again when the consumer drains a bank. The bit changes one cycle after the clock edge that completes the write or the read.
- R3: `irq_n` is 0 exactly when any `req_type` bit is 1, and it changes in the same cycle as `req_type`.
- R4: The control stream (`host_strm`/`rd_strm` = 0) has two banks. A bank is complete after 128 bytes have been written to it.
- R5: With `cfg_one_chan`=0, sample channels 0 and 1 (`host_strm`/`rd_strm` = 1, selected by `*_chan`) each have two 64-byte banks. The two channels are fully independent.
- R6: With `cfg_one_chan`=1, channel 0 has two 128-byte banks. Channel 1 writes are dropped, channel 1 reads underrun, and `req_type` bit 1 stays 0.
- R7: A change of `cfg_one_chan` empties every sample bank and restarts both sample channels at their first bank. The control stream is untouched.
- R8: The consumer receives the bytes of each stream or channel in the order they were written, bank after bank. It never receives a byte from a bank whose block is not complete.
- R9: A read accepted at a clock edge presents its byte on `rd_data`, with `rd_valid`=1, until the next edge. The pulse lasts one cycle.
- R10: A read from an empty or partly written bank gives `rd_data`=0 and `rd_underrun`=1 for one cycle, and no read pointer moves.
- R11: A host write to a stream or channel with no empty bank is dropped.
- R12: If, in one cycle, the host writes the last byte of one bank and the consumer reads the last byte of the other bank of the same stream, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_one_chan | input | 1 | 1: single sample channel with 128-byte banks; 0: two channels |
| host_wr | input | 1 | Host byte write strobe |
| host_strm | input | 1 | Host target stream: 0 control, 1 sample |
| host_chan | input | 1 | Host target sample channel |
| host_data | input | 8 | Host write byte |
| rd_en | input | 1 | Consumer read strobe |
| rd_strm | input | 1 | Consumer stream: 0 control, 1 sample |
| rd_chan | input | 1 | Consumer sample channel |
| rd_data | output | 8 | Byte read (0 on underrun) |
| rd_valid | output | 1 | A byte was delivered |
| rd_underrun | output | 1 | Read hit an empty or partial bank |
| req_type | output | 3 | Refill requests: bit 2 control, bit 1 channel 1, bit 0 channel 0 |
| irq_n | output | 1 | Active-low refill interrupt |

## Verification
The host can close one bank in the same cycle that the consumer empties the other bank of the same stream. Both events then update the bank-state vector at the same edge. The bench sets this up on the control stream. It writes 127 bytes into one bank and reads 127 bytes from the full bank. Then a single cycle carries the final write and the final read together. The bench judges the result from three things: the byte returned, the request bit set one cycle later, and the newly closed block being readable in full. A mode change arriving together with a sample read is covered by the rule that the change takes priority.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic {STRM_CTRL = 1'b0, STRM_SMP = 1'b1} strm_e;
  localparam int REQ_W    = 3;
  localparam int REQ_CTRL = 2;
  localparam int REQ_CH1  = 1;
  localparam int REQ_CH0  = 0;
endpackage

// File: rtl/sbb_mem.sv
module sbb_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
    if (re) q <= store[ra];
  end
endmodule

// File: rtl/sbb_ring.sv
// Bank pointer and fill-state logic for one ping-pong stream.
module sbb_ring #(
  parameter int NBANKS  = 2,
  parameter int MAX_LEN = 128,
  localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int OW = $clog2(MAX_LEN),
  localparam int AW = $clog2(NBANKS * MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          half,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          space,
  output logic          rd_ok
);
  logic [NBANKS-1:0] full_q, full_d;
  logic [BW-1:0]     wb_q, rb_q;
  logic [OW-1:0]     wo_q, ro_q;
  logic [OW-1:0]     last_off;
  logic              do_w, do_r, w_end, r_end;

  function automatic logic [BW-1:0] nxt(input logic [BW-1:0] b);
    return (b == BW'(NBANKS - 1)) ? '0 : b + BW'(1);
  endfunction

  assign last_off = half ? OW'(MAX_LEN / 2 - 1) : OW'(MAX_LEN - 1);
  assign space    = !full_q[wb_q];
  assign rd_ok    = full_q[rb_q];
  assign do_w     = wr_en && space;
  assign do_r     = rd_en && rd_ok;
  assign w_end    = do_w && (wo_q == last_off);
  assign r_end    = do_r && (ro_q == last_off);

  assign wr_addr = half ? AW'(wb_q) * AW'(MAX_LEN / 2) + AW'(wo_q)
                        : AW'(wb_q) * AW'(MAX_LEN) + AW'(wo_q);
  assign rd_addr = half ? AW'(rb_q) * AW'(MAX_LEN / 2) + AW'(ro_q)
                        : AW'(rb_q) * AW'(MAX_LEN) + AW'(ro_q);

  always_comb begin
    full_d = full_q;
    if (w_end) full_d[wb_q] = 1'b1;
    if (r_end) full_d[rb_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full_q <= '0;
      wb_q   <= '0;
      rb_q   <= '0;
      wo_q   <= '0;
      ro_q   <= '0;
    end else begin
      full_q <= full_d;
      if (do_w) begin
        wo_q <= w_end ? '0 : wo_q + OW'(1);
        if (w_end) wb_q <= nxt(wb_q);
      end
      if (do_r) begin
        ro_q <= r_end ? '0 : ro_q + OW'(1);
        if (r_end) rb_q <= nxt(rb_q);
      end
    end
  end
endmodule

// File: rtl/stream_bank_buffer.sv
module stream_bank_buffer #(
  parameter int DW             = 8,
  parameter int CTRL_BANKS     = 2,
  parameter int CTRL_BANK_LEN  = 128,
  parameter int SMP_BANKS      = 4,
  parameter int SMP_BANK_LEN   = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_one_chan,
  input  logic          host_wr,
  input  logic          host_strm,
  input  logic          host_chan,
  input  logic [DW-1:0] host_data,
  input  logic          rd_en,
  input  logic          rd_strm,
  input  logic          rd_chan,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_underrun,
  output logic [2:0]    req_type,
  output logic          irq_n
);
  import sbb_pkg::*;

  localparam int NCH        = 2;
  localparam int CH_BANKS   = SMP_BANKS / NCH;
  localparam int CH_MAX_LEN = SMP_BANK_LEN * NCH;
  localparam int C_DEPTH    = CTRL_BANKS * CTRL_BANK_LEN;
  localparam int S_DEPTH    = SMP_BANKS * SMP_BANK_LEN;
  localparam int C_AW       = $clog2(C_DEPTH);
  localparam int S_AW       = $clog2(S_DEPTH);

  logic mode_q, flush;
  assign flush = (mode_q != cfg_one_chan);

  // control stream
  logic [C_AW-1:0] c_wa, c_ra;
  logic            c_space, c_rdok, c_wen, c_ren;
  logic [DW-1:0]   c_q;

  assign c_wen = host_wr && (host_strm == STRM_CTRL);
  assign c_ren = rd_en && (rd_strm == STRM_CTRL);

  sbb_ring #(.NBANKS(CTRL_BANKS), .MAX_LEN(CTRL_BANK_LEN)) u_cring (
    .clk(clk), .rst(rst), .flush(1'b0), .half(1'b0),
    .wr_en(c_wen), .rd_en(c_ren),
    .wr_addr(c_wa), .rd_addr(c_ra), .space(c_space), .rd_ok(c_rdok)
  );

  sbb_mem #(.DEPTH(C_DEPTH), .DW(DW)) u_cmem (
    .clk(clk), .we(c_wen && c_space), .wa(c_wa), .wd(host_data),
    .re(c_ren && c_rdok), .ra(c_ra), .q(c_q)
  );

  // sample stream: one ring per channel over a shared memory
  logic [S_AW-1:0] s_wa [NCH];
  logic [S_AW-1:0] s_ra [NCH];
  logic [NCH-1:0]  s_space, s_rdok, s_wen, s_ren, s_act;
  logic [DW-1:0]   s_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [S_AW-1:0] ring_wa, ring_ra;
    assign s_act[ch] = (ch == 0) || !mode_q;
    assign s_wen[ch] = host_wr && (host_strm == STRM_SMP) &&
                       (host_chan == 1'(ch)) && s_act[ch];
    assign s_ren[ch] = rd_en && (rd_strm == STRM_SMP) &&
                       (rd_chan == 1'(ch)) && s_act[ch];

    sbb_ring #(.NBANKS(CH_BANKS), .MAX_LEN(CH_MAX_LEN)) u_sring (
      .clk(clk), .rst(rst), .flush(flush), .half(!mode_q),
      .wr_en(s_wen[ch]), .rd_en(s_ren[ch]),
      .wr_addr(ring_wa), .rd_addr(ring_ra),
      .space(s_space[ch]), .rd_ok(s_rdok[ch])
    );

    assign s_wa[ch] = ring_wa + S_AW'(ch * (S_DEPTH / NCH));
    assign s_ra[ch] = ring_ra + S_AW'(ch * (S_DEPTH / NCH));
  end

  logic s_wr_hit, s_rd_hit;
  assign s_wr_hit = |(s_wen & s_space) && !flush;
  assign s_rd_hit = |(s_ren & s_rdok) && !flush;

  sbb_mem #(.DEPTH(S_DEPTH), .DW(DW)) u_smem (
    .clk(clk), .we(s_wr_hit), .wa(s_wa[host_chan]), .wd(host_data),
    .re(s_rd_hit), .ra(s_ra[rd_chan]), .q(s_q)
  );

  // consumer result and request registers
  logic          ok_sel;
  logic          valid_q, under_q, strm_q;
  logic [2:0]    req_d;

  assign ok_sel = (rd_strm == STRM_CTRL) ? c_rdok : s_rd_hit;

  always_comb begin
    req_d           = '0;
    req_d[REQ_CTRL] = c_space;
    req_d[REQ_CH1]  = s_space[1] && s_act[1];
    req_d[REQ_CH0]  = s_space[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= cfg_one_chan;
      valid_q  <= 1'b0;
      under_q  <= 1'b0;
      strm_q   <= 1'b0;
      req_type <= {1'b1, ~cfg_one_chan, 1'b1};
      irq_n    <= 1'b0;
    end else begin
      mode_q   <= cfg_one_chan;
      valid_q  <= rd_en && ok_sel;
      under_q  <= rd_en && !ok_sel;
      strm_q   <= rd_strm;
      req_type <= req_d;
      irq_n    <= ~|req_d;
    end
  end

  assign rd_data     = valid_q ? (strm_q ? s_q : c_q) : '0;
  assign rd_valid    = valid_q;
  assign rd_underrun = under_q;
endmodule

// File: rtl/sbb_chk.sv
module sbb_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_one_chan,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_underrun,
  input logic [2:0] req_type,
  input logic       irq_n
);
  // R3
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n == (req_type == 3'b000));

  // R10
  under_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_underrun |-> (rd_data == 8'h00));

  // R9
  valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_underrun));

  // R9
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R10
  under_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_underrun |-> $past(rd_en));

  // R6
  one_chan_req_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_one_chan && $past(cfg_one_chan) && $past(cfg_one_chan, 2))
      |-> !req_type[1]);
endmodule

bind stream_bank_buffer sbb_chk u_chk (
  .clk(clk), .rst(rst), .cfg_one_chan(cfg_one_chan), .rd_en(rd_en),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_underrun(rd_underrun),
  .req_type(req_type), .irq_n(irq_n)
);

// File: tb/sim_stream_bank_buffer.sv
module sim_stream_bank_buffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_one_chan = 1'b0;
  logic       host_wr = 1'b0, host_strm = 1'b0, host_chan = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       rd_en = 1'b0, rd_strm = 1'b0, rd_chan = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, rd_underrun, irq_n;
  logic [2:0] req_type;

  int checks = 0, failures = 0;
  logic [7:0] got_d;
  logic       got_v, got_u;

  always #5 clk = ~clk;

  stream_bank_buffer u0 (
    .clk(clk), .rst(rst), .cfg_one_chan(cfg_one_chan),
    .host_wr(host_wr), .host_strm(host_strm), .host_chan(host_chan),
    .host_data(host_data), .rd_en(rd_en), .rd_strm(rd_strm),
    .rd_chan(rd_chan), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_underrun(rd_underrun), .req_type(req_type), .irq_n(irq_n)
  );

  function automatic logic [7:0] pat(int tag, int blk, int idx);
    return 8'((tag * 61 + blk * 37 + idx * 3 + 1) & 255);
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one clock: drive at negedge, capture results at the next negedge
  task automatic cyc(bit w, bit ws, bit wc, logic [7:0] wd,
                     bit r, bit rs, bit rc);
    host_wr = w; host_strm = ws; host_chan = wc; host_data = wd;
    rd_en = r; rd_strm = rs; rd_chan = rc;
    @(negedge clk);
    got_d = rd_data; got_v = rd_valid; got_u = rd_underrun;
    host_wr = 0; rd_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(bit s, bit c, int tag, int blk, int from, int n);
    for (int i = from; i < from + n; i++) cyc(1, s, c, pat(tag, blk, i), 0, 0, 0);
  endtask

  // R8 R9: every delivered byte checked in order one cycle after the read
  task automatic drain(bit s, bit c, int tag, int blk, int from, int n, string rq);
    for (int i = from; i < from + n; i++) begin
      cyc(0, 0, 0, 0, 1, s, c);
      chk(got_v && !got_u && got_d == pat(tag, blk, i), rq, got_d, pat(tag, blk, i));
    end
  endtask

  task automatic under(bit s, bit c, string rq);
    cyc(0, 0, 0, 0, 1, s, c);
    chk(got_u && !got_v && got_d == 0, rq, {got_u, got_v, got_d}, 32'h200);
  endtask

  task automatic req_is(logic [2:0] e, string rq);
    chk(req_type == e && irq_n == (e == 0), rq, {irq_n, req_type}, {(e == 0), e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 R3 reset state
    req_is(3'b111, "R1");
    chk(rd_valid == 0, "R1", rd_valid, 0);
    under(0, 0, "R10");

    // R4 R2 control stream fill
    fill(0, 0, 0, 0, 0, 128); idle(1);
    req_is(3'b111, "R2");
    fill(0, 0, 0, 1, 0, 128); idle(1);
    req_is(3'b011, "R2");
    fill(0, 0, 0, 9, 0, 3); // R11 dropped: no empty bank
    drain(0, 0, 0, 0, 0, 128, "R4"); idle(1);
    req_is(3'b111, "R2");
    chk(rd_valid == 0, "R9", rd_valid, 0);
    drain(0, 0, 0, 1, 0, 128, "R8");
    under(0, 0, "R11");

    // R5 R10 two-channel sample: partial bank must not be read
    fill(1, 0, 1, 0, 0, 63);
    under(1, 0, "R10");
    fill(1, 0, 1, 0, 63, 1);
    fill(1, 1, 2, 0, 0, 64); fill(1, 1, 2, 1, 0, 64);
    idle(1); req_is(3'b101, "R5");
    fill(1, 0, 1, 1, 0, 64);
    fill(0, 0, 0, 2, 0, 128); fill(0, 0, 0, 3, 0, 128);
    idle(1); req_is(3'b000, "R3");
    drain(1, 1, 2, 0, 0, 64, "R5"); idle(1);
    req_is(3'b010, "R5");
    drain(1, 0, 1, 0, 0, 64, "R5"); idle(1);
    req_is(3'b011, "R2");
    drain(1, 0, 1, 1, 0, 64, "R8");
    drain(1, 1, 2, 1, 0, 64, "R8");
    under(1, 1, "R10");

    // R12 simultaneous bank close and bank drain on control stream
    drain(0, 0, 0, 2, 0, 128, "R8");
    fill(0, 0, 0, 4, 0, 128);
    drain(0, 0, 0, 3, 0, 128, "R8");
    fill(0, 0, 0, 5, 0, 127);
    drain(0, 0, 0, 4, 0, 127, "R12");
    cyc(1, 0, 0, pat(0, 5, 127), 1, 0, 0);
    chk(got_v && got_d == pat(0, 4, 127), "R12", got_d, pat(0, 4, 127));
    idle(1); chk(req_type[2] == 1, "R12", req_type, 3'b100);
    drain(0, 0, 0, 5, 0, 128, "R12");
    under(0, 0, "R12");

    // R7 R6 mode switch
    fill(1, 0, 1, 7, 0, 64);
    fill(0, 0, 0, 6, 0, 128);
    cfg_one_chan = 1; idle(2);
    req_is(3'b101, "R7");
    under(1, 0, "R7");
    fill(1, 0, 1, 10, 0, 128); idle(1);
    chk(req_type[0] == 1, "R6", req_type, 3'b101);
    fill(1, 0, 1, 11, 0, 128);
    fill(1, 1, 2, 12, 0, 64); idle(1);
    req_is(3'b100, "R6");
    under(1, 1, "R6");
    drain(0, 0, 0, 6, 0, 128, "R7");
    drain(1, 0, 1, 10, 0, 128, "R6");
    drain(1, 0, 1, 11, 0, 128, "R6");
    under(1, 0, "R8");

    // back to two channels: banks are 64 again
    cfg_one_chan = 0; idle(2);
    req_is(3'b111, "R7");
    fill(1, 0, 1, 13, 0, 64); fill(1, 0, 1, 14, 0, 64); idle(1);
    req_is(3'b110, "R5");
    drain(1, 0, 1, 13, 0, 64, "R5");
    drain(1, 0, 1, 14, 0, 64, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule